// File: doc/BRIEF.md
# Power-Down and Wake-Up Gate for a Card Interface

This block sits between a host-controlled power-down pin and the card activation sequencer of a smart-card interface. While no card session is running, raising the power-down request shuts the analog section off. Card presence is still watched in that mode, and an inserted card raises the interrupt line. When the request is dropped, the block holds the interface in a stabilization window of a fixed number of time-base ticks before it declares itself ready. The same wait applies once after reset.

The host's Start/Stop bit is passed to the sequencer only as a one-clock qualified start pulse. That pulse is produced only for a rising edge of Start/Stop seen while the block is ready. An edge that arrives during the reset wait, during power-down or inside the stabilization window is dropped. A bit that is simply held high across the window never turns into a start, so the host has to lower and raise it again. A power-down request made while the sequencer reports an active session is ignored.

The wait length is a parameter counted in ticks of a free-running time-base strobe `tick_i`, so a short value can stand in for the roughly 10 ms wait.

Top module: `pwrdn_wake_gate`

## Requirements
- R1: After reset, `analog_off_o`, `irq_o` and `start_pulse_o` are 0. `irq_o` stays 0 until STAB_TICKS clock edges with `tick_i` high have passed, and it is 1 from the cycle after the edge that carried the last of those ticks.
- R2: When `pd_req_i` is 1 and `session_active_i` is 0 at a clock edge, `analog_off_o` is 1 after that edge.
- R3: While `session_active_i` is 1, a high `pd_req_i` leaves `analog_off_o` at 0.
- R4: The edge after `pd_req_i` falls in power-down clears `analog_off_o`. Ready is then reached only after STAB_TICKS further edges with `tick_i` high.
- R5: In power-down, `irq_o` copies `card_present_i` with one clock of delay, so a card insertion raises it.
- R6: In the ready state, a rising edge of `start_bit_i` (0 at one clock edge, 1 at the next) makes `start_pulse_o` 1 for exactly one cycle, just after the edge that saw the 1.
- R7: A rising edge of `start_bit_i` during the reset wait, power-down or stabilization produces no pulse, and a level held high into the ready state produces none either. A new 0-then-1 toggle after ready does produce one.
- R8: `irq_o` is 0 throughout the stabilization window and becomes 1 when the block reaches ready.
- R9: A Start/Stop rising edge seen at the same clock edge as an honoured power-down request produces no pulse.
- R10: Only edges with `tick_i` high advance the wait, so with `tick_i` held low the block stays in the window with `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base strobe, one clock wide per tick |
| pd_req_i | input | 1 | Power-down request, active high |
| card_present_i | input | 1 | Card presence level |
| start_bit_i | input | 1 | Host Start/Stop bit level |
| session_active_i | input | 1 | Sequencer reports a card session in progress |
| analog_off_o | output | 1 | Disable for the analog section |
| irq_o | output | 1 | Interrupt output |
| start_pulse_o | output | 1 | Qualified one-cycle start pulse to the sequencer |

## Verification
The bench aims at Start/Stop edges that land in the wrong state: during the reset wait, during power-down, and at the same edge as an honoured power-down request. A design that let any of these through would start a session on an unstable supply. It also holds Start/Stop high across a whole stabilization window, which catches a level-sensitive qualifier that fires as soon as ready is reached. It counts the ticks from power-down release to `irq_o` rising, and it stalls the time base mid-window, so a timer that is off by one tick or counts clocks instead of ticks shows up at once. Power-down requests during an active session check that the session guard is not bypassed.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_READY = 2'd1,
        ST_PDOWN = 2'd2,
        ST_STAB  = 2'd3
    } pwg_state_e;

    typedef struct packed {
        pwg_state_e state;
        logic       analog_off;
        logic       irq;
        logic       pulse;
    } pwg_regs_t;
endpackage

// File: rtl/pwg_edge_detect.sv
module pwg_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pwg_stab_timer.sv
module pwg_stab_timer #(
    parameter int STAB_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(STAB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STAB_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && tick_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clear_i)           cnt_d = '0;
        else if (done_o)       cnt_d = '0;
        else if (run_i && tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: the count never passes the last tick value
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/pwrdn_wake_gate.sv
module pwrdn_wake_gate #(
    parameter int STAB_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pd_req_i,
    input  logic card_present_i,
    input  logic start_bit_i,
    input  logic session_active_i,
    output logic analog_off_o,
    output logic irq_o,
    output logic start_pulse_o
);
    import pwg_pkg::*;

    pwg_regs_t r_d, r_q;
    logic      start_rise;
    logic      wait_done;
    logic      go_pd;
    logic      tmr_clear, tmr_run;

    pwg_edge_detect i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (start_bit_i),
        .rise_o  (start_rise)
    );

    pwg_stab_timer #(.STAB_TICKS(STAB_TICKS)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .run_i   (tmr_run),
        .tick_i  (tick_i),
        .done_o  (wait_done)
    );

    always_comb begin
        go_pd     = pd_req_i && !session_active_i;
        tmr_clear = (r_q.state == ST_PDOWN) || (r_q.state == ST_READY);
        tmr_run   = (r_q.state == ST_POR) || (r_q.state == ST_STAB);

        r_d = r_q;
        unique case (r_q.state)
            ST_POR, ST_STAB: begin
                if (go_pd)          r_d.state = ST_PDOWN;
                else if (wait_done) r_d.state = ST_READY;
            end
            ST_READY: begin
                if (go_pd) r_d.state = ST_PDOWN;
            end
            ST_PDOWN: begin
                if (!pd_req_i) r_d.state = ST_STAB;
            end
            default: r_d.state = ST_POR;
        endcase

        r_d.pulse      = (r_q.state == ST_READY) && start_rise && !go_pd;
        r_d.analog_off = (r_d.state == ST_PDOWN);
        unique case (r_d.state)
            ST_READY: r_d.irq = 1'b1;
            ST_PDOWN: r_d.irq = card_present_i;
            default:  r_d.irq = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state      <= ST_POR;
            r_q.analog_off <= 1'b0;
            r_q.irq        <= 1'b0;
            r_q.pulse      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign analog_off_o  = r_q.analog_off;
    assign irq_o         = r_q.irq;
    assign start_pulse_o = r_q.pulse;

    // R1: interrupt held low during the reset wait
    p_por_irq_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_POR) |-> !irq_o);
    // R2: honoured request turns analog off next cycle
    p_pd_honored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req_i && !session_active_i) |=> analog_off_o);
    // R3: an active session keeps the analog section on
    p_session_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (session_active_i && !analog_off_o) |=> !analog_off_o);
    // R6: the start pulse is one cycle wide
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |=> !start_pulse_o);
    // R7: no start pulse while powered down
    p_no_pulse_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |-> !analog_off_o);
    // R8: leaving power-down enters the window with interrupt low
    p_stab_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(analog_off_o) |-> !irq_o);
    // R10: without a tick the window does not end
    p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STAB && !tick_i && !pd_req_i) |=> (r_q.state == ST_STAB));
endmodule

// File: tb/test_pwrdn_wake_gate.sv
module test_pwrdn_wake_gate;
    localparam int STAB = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic pd_req_i = 1'b0;
    logic card_present_i = 1'b0;
    logic start_bit_i = 1'b0;
    logic session_active_i = 1'b0;
    logic analog_off_o, irq_o, start_pulse_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tick_cnt = 0;
    int pulse_cnt = 0;
    bit tick_en = 1'b1;
    bit finished = 1'b0;

    // reference model state: 0 reset wait, 1 ready, 2 power-down, 3 window
    int  m_st = 0;
    int  m_cnt = 0;
    bit  m_prev = 1'b0;
    bit  e_off = 1'b0, e_irq = 1'b0, e_pulse = 1'b0;

    always #4 clk = ~clk;

    pwrdn_wake_gate #(.STAB_TICKS(STAB)) i_pwrdn_wake_gate (
        .clk              (clk),
        .rst_n            (rst_n),
        .tick_i           (tick_i),
        .pd_req_i         (pd_req_i),
        .card_present_i   (card_present_i),
        .start_bit_i      (start_bit_i),
        .session_active_i (session_active_i),
        .analog_off_o     (analog_off_o),
        .irq_o            (irq_o),
        .start_pulse_o    (start_pulse_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (irq_o !== 1'b1 && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(tag, irq_o, 1'b1);
    endtask

    // time base
    always @(negedge clk) begin
        cyc++;
        tick_i <= tick_en && (cyc % 4 == 0);
    end

    // behavioural reference, advanced on each edge
    always @(posedge clk) begin
        bit rise, gopd;
        if (rst_n && tick_i) tick_cnt++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_prev = 0;
            e_off = 0; e_irq = 0; e_pulse = 0;
        end else begin
            rise = start_bit_i && !m_prev;
            m_prev = start_bit_i;
            gopd = pd_req_i && !session_active_i;
            e_pulse = (m_st == 1) && rise && !gopd;
            if (m_st == 0 || m_st == 3) begin
                if (gopd) m_st = 2;
                else if (tick_i) begin
                    m_cnt++;
                    if (m_cnt == STAB) begin m_st = 1; m_cnt = 0; end
                end
            end else if (m_st == 1) begin
                if (gopd) m_st = 2;
            end else begin
                m_cnt = 0;
                if (!pd_req_i) m_st = 3;
            end
            e_off = (m_st == 2);
            e_irq = (m_st == 1) ? 1'b1 : (m_st == 2) ? card_present_i : 1'b0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (start_pulse_o === 1'b1) pulse_cnt++;
            chk("R2 analog_off vs model", analog_off_o, e_off);
            chk("R8 irq vs model", irq_o, e_irq);
            chk("R6 start_pulse vs model", start_pulse_o, e_pulse);
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        int pcount;
        repeat (3) @(negedge clk);
        chk("R1 reset analog_off", analog_off_o, 1'b0);
        chk("R1 reset irq", irq_o, 1'b0);
        chk("R1 reset pulse", start_pulse_o, 1'b0);
        rst_n = 1'b1;

        // R7: toggle during the reset wait
        @(negedge clk); start_bit_i = 1'b1;
        @(negedge clk); chk("R7 no pulse in reset wait", start_pulse_o, 1'b0);
        start_bit_i = 1'b0;
        @(negedge clk); chk("R1 irq low in reset wait", irq_o, 1'b0);
        wait_irq("R1 irq rises after wait");
        chk_int("R1 ticks before ready", tick_cnt, STAB);

        // R6: qualified start
        start_bit_i = 1'b1;
        @(negedge clk); chk("R6 pulse after edge", start_pulse_o, 1'b1);
        @(negedge clk); chk("R6 pulse one wide", start_pulse_o, 1'b0);
        start_bit_i = 1'b0;

        // R3: request during a session
        session_active_i = 1'b1; pd_req_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 session keeps analog on", analog_off_o, 1'b0);
        pd_req_i = 1'b0; session_active_i = 1'b0;
        @(negedge clk);

        // R2: honoured request
        pd_req_i = 1'b1;
        @(negedge clk); chk("R2 analog off", analog_off_o, 1'b1);

        // R5: card presence in power-down
        card_present_i = 1'b1;
        @(negedge clk); chk("R5 insertion raises irq", irq_o, 1'b1);
        card_present_i = 1'b0;
        @(negedge clk); chk("R5 removal lowers irq", irq_o, 1'b0);
        card_present_i = 1'b1;

        // R7: edge in power-down, level held through the window
        start_bit_i = 1'b1;
        @(negedge clk); chk("R7 no pulse in power-down", start_pulse_o, 1'b0);
        pcount = pulse_cnt;
        pd_req_i = 1'b0;
        @(negedge clk);
        chk("R4 analog on after release", analog_off_o, 1'b0);
        chk("R8 irq low in window", irq_o, 1'b0);
        base = tick_cnt;
        wait_irq("R8 irq high at ready");
        chk_int("R4 window ticks", tick_cnt - base, STAB);
        repeat (3) @(negedge clk);
        chk_int("R7 held level gives no pulse", pulse_cnt, pcount);
        start_bit_i = 1'b0;
        @(negedge clk); start_bit_i = 1'b1;
        @(negedge clk); chk("R7 fresh toggle pulses", start_pulse_o, 1'b1);

        // R9: edge coinciding with an honoured request
        start_bit_i = 1'b0;
        @(negedge clk); start_bit_i = 1'b1; pd_req_i = 1'b1;
        @(negedge clk);
        chk("R9 no pulse with power-down", start_pulse_o, 1'b0);
        chk("R9 analog off", analog_off_o, 1'b1);
        start_bit_i = 1'b0;

        // R10: stalled time base keeps the window open
        tick_en = 1'b0;
        @(negedge clk); pd_req_i = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10 no ready without ticks", irq_o, 1'b0);
        tick_en = 1'b1;
        wait_irq("R10 ready after ticks resume");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule